// File: doc/BRIEF.md
# SPI Port with Configuration and Status Register

This block is a single-byte SPI port that a processor drives through a small byte-wide register bus. One mode bit selects the role. As a master, the port generates SCK from the system clock through a programmable divider. As a slave, it follows an external SCK and takes part in transfers only while its select pin is held low. Clock polarity and clock phase apply to both roles.

Each transfer exchanges 8 bits, most significant bit first. Writing the data register loads a one-byte transmit buffer. A completed transfer places the received byte in a one-byte receive buffer, which software reads from the same address. The register bus has no back-pressure: every write and read is accepted in the cycle it is presented. A new received byte overwrites any byte that has not yet been read.

A single register carries both the configuration and the status. The status part reports:
- busy;
- a filtered slave-select flag;
- the raw level of the select pin;
- a shift-register-empty flag;
- a receive-buffer-empty flag.

The last two flags have meaning only in slave mode and read 1 while the port is a master.

Top module: `spi_port`

## Requirements
- R1: After reset, address 0 reads 0x07, address 2 (divider) reads 0x00, and SCK driven by the port sits low.
- R2: Address 0 bit 6 selects master (1) or slave (0), bit 5 is clock phase, bit 4 is clock polarity; these three bits are writable and read back, and writes to the other bits of address 0 have no effect.
- R3: In master mode SCK idles at the polarity level, and each SCK half period lasts (divider+1) system clocks, with the divider held at address 2.
- R4: In master mode a write to address 1 starts an 8-bit exchange, most significant bit first; address 0 bit 7 (busy) reads 1 while it runs, and the received byte is read back from address 1 afterwards.
- R5: With phase 0, data is sampled on the first SCK edge of each bit and the outgoing bit is valid before that edge; with phase 1, the outgoing bit changes on the first edge and data is sampled on the second. This holds in both roles and for both polarities.
- R6: Address 0 bit 3 (selected) reads 1 while the select pin is low, but only after the pin has held a new level for 3 consecutive system clocks; a shorter pulse does not change the flag.
- R7: Address 0 bit 2 reads the present level of the select pin, unfiltered.
- R8: In slave mode, address 0 bit 1 (shift-register empty) drops to 0 when a byte moves from the transmit buffer into the shift register or when an SCK edge arrives while selected. It returns to 1 when a byte completes and no transmit byte is waiting.
- R9: In slave mode, address 0 bit 0 (receive empty) drops to 0 when a received byte completes and returns to 1 once address 1 has been read.
- R10: In master mode, address 0 bits 1 and 0 both read 1, whatever the buffer state.
- R11: In slave mode, SCK activity while the filtered select is high has no effect: no byte is received, busy stays 0, and the shift-register-empty flag does not change.
- R12: In slave mode, busy reads 1 from the first SCK edge of a selected transfer until its eighth bit completes, and it clears at once if the port is deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 1 empties the receive buffer |
| reg_addr | input | 2 | Register address: 0 configuration/status, 1 data, 2 divider |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| sck_i | input | 1 | SCK from an external master (slave mode) |
| sck_o | output | 1 | SCK generated by the port (master mode) |
| sck_oe | output | 1 | SCK output enable, high in master mode |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | MOSI output enable, high in master mode |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | MISO output enable, high when the port is a selected slave |
| nss_i | input | 1 | Slave-select pin, active low |

## Verification
The assertions assume the following about the inputs:
- The select pin is held high through reset, so the filter history is valid from the first cycle.
- The mode and clock settings are not rewritten while a transfer is in flight.
- In slave mode, SCK and MOSI change slowly compared with the system clock.

The bench respects these assumptions. It changes configuration only while the port is idle. When it acts as the external master, it holds each SCK level for 8 system clocks and always sets SCK to its idle level before pulling select low. In master-mode tests, its model of the remote slave changes MISO only just after the SCK edges that the port itself generates.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int XFER_W = 8;
  localparam int CNT_W  = $clog2(XFER_W);

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_DATA = 2'd1,
    A_DIV  = 2'd2
  } reg_addr_e;

  // Bit positions in the configuration/status register
  localparam int B_BUSY   = 7;
  localparam int B_MASTER = 6;
  localparam int B_PHASE  = 5;
  localparam int B_POLAR  = 4;
  localparam int B_SEL    = 3;
  localparam int B_RAW    = 2;
  localparam int B_SHE    = 1;
  localparam int B_RXE    = 0;
endpackage

// File: rtl/spi_nss_filter.sv
module spi_nss_filter #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic filt
);
  logic [STABLE-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '1;
      filt <= 1'b1;
    end else begin
      hist <= {hist[STABLE-2:0], pin};
      if (&hist)        filt <= 1'b1;
      else if (~|hist)  filt <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         lead,
  input  logic         trail,
  input  logic         cpha,
  input  logic         in_bit,
  output logic         out_bit,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          samp;
  logic          in_sel;

  assign in_sel  = cpha ? in_bit : samp;
  assign rx_byte = {sr[W-2:0], in_sel};
  assign done    = trail && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      samp    <= 1'b0;
      out_bit <= 1'b0;
    end else if (load) begin
      sr  <= load_byte;
      cnt <= '0;
      if (!cpha) out_bit <= load_byte[W-1];
    end else if (clr) begin
      cnt <= '0;
    end else if (lead) begin
      if (cpha) out_bit <= sr[W-1];
      else      samp    <= in_bit;
    end else if (trail) begin
      sr  <= {sr[W-2:0], in_sel};
      cnt <= cnt + 1'b1;
      if (!cpha) out_bit <= sr[W-2];
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int NSS_STABLE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       nss_i
);
  logic              master_q, cpha_q, cpol_q;
  logic [DIV_W-1:0]  div_q;
  logic [XFER_W-1:0] txbuf, rxbuf, rx_byte;
  logic              tx_full, rx_full;
  logic              m_busy, m_phase, sck_lvl;
  logic              s_busy, sr_empty, reload_pend;
  logic [2:0]        ss;
  logic [1:0]        ms;
  logic              nss_filt, sel, tick;
  logic              m_lead, m_trail, s_lead, s_trail, lead, trail;
  logic              s_lvl_now, s_lvl_prev;
  logic              m_start, s_load, load, clr, done, core_out, in_bit;
  logic              wr_cfg, wr_data, wr_div, rd_data, busy;
  logic [7:0]        status;

  spi_nss_filter #(.STABLE(NSS_STABLE)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin(nss_i), .filt(nss_filt)
  );

  spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(master_q && m_busy), .div(div_q), .tick(tick)
  );

  spi_shift_core #(.W(XFER_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_byte(txbuf),
    .lead(lead), .trail(trail), .cpha(cpha_q), .in_bit(in_bit),
    .out_bit(core_out), .done(done), .rx_byte(rx_byte)
  );

  assign sel     = !nss_filt;
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign wr_div  = reg_wr && (reg_addr == A_DIV);
  assign rd_data = reg_rd && (reg_addr == A_DATA);

  // Edge events: master from divider ticks, slave from synchronized SCK
  assign m_lead     = master_q && m_busy && tick && !m_phase;
  assign m_trail    = master_q && m_busy && tick &&  m_phase;
  assign s_lvl_now  = ss[1] ^ cpol_q;
  assign s_lvl_prev = ss[2] ^ cpol_q;
  assign s_lead     = !master_q && sel &&  s_lvl_now && !s_lvl_prev;
  assign s_trail    = !master_q && sel && !s_lvl_now &&  s_lvl_prev;
  assign lead       = m_lead  || s_lead;
  assign trail      = m_trail || s_trail;
  assign in_bit     = master_q ? miso_i : ms[1];

  assign m_start = master_q && !m_busy && tx_full;
  assign s_load  = !master_q && tx_full && !s_busy && !s_lead && !s_trail
                   && (sr_empty || reload_pend);
  assign load    = m_start || s_load;
  assign clr     = !master_q && !sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      cpha_q   <= 1'b0;
      cpol_q   <= 1'b0;
      div_q    <= '0;
      ss       <= '0;
      ms       <= '0;
    end else begin
      if (wr_cfg) begin
        master_q <= reg_wdata[B_MASTER];
        cpha_q   <= reg_wdata[B_PHASE];
        cpol_q   <= reg_wdata[B_POLAR];
      end
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      ss <= {ss[1:0], sck_i};
      ms <= {ms[0], mosi_i};
    end
  end

  // Transmit and receive buffers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf   <= '0;
      tx_full <= 1'b0;
      rxbuf   <= '0;
      rx_full <= 1'b0;
    end else begin
      if (load) tx_full <= 1'b0;
      if (wr_data) begin
        txbuf   <= reg_wdata;
        tx_full <= 1'b1;
      end
      if (rd_data) rx_full <= 1'b0;
      if (done) begin
        rxbuf   <= rx_byte;
        rx_full <= 1'b1;
      end
    end
  end

  // Master sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy  <= 1'b0;
      m_phase <= 1'b0;
      sck_lvl <= 1'b0;
    end else if (!master_q) begin
      m_busy  <= 1'b0;
      m_phase <= 1'b0;
      sck_lvl <= 1'b0;
    end else if (m_start) begin
      m_busy  <= 1'b1;
      m_phase <= 1'b0;
      sck_lvl <= 1'b0;
    end else if (m_lead) begin
      m_phase <= 1'b1;
      sck_lvl <= 1'b1;
    end else if (m_trail) begin
      m_phase <= 1'b0;
      sck_lvl <= 1'b0;
      if (done) m_busy <= 1'b0;
    end
  end

  // Slave state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_busy      <= 1'b0;
      sr_empty    <= 1'b1;
      reload_pend <= 1'b0;
    end else begin
      if (master_q || !sel)     s_busy <= 1'b0;
      else if (s_lead)          s_busy <= 1'b1;
      else if (s_trail && done) s_busy <= 1'b0;

      if (s_load)                   sr_empty <= 1'b0;
      else if (s_trail && done)     sr_empty <= !tx_full;
      else if (s_lead || s_trail)   sr_empty <= 1'b0;

      if (master_q || s_load)                 reload_pend <= 1'b0;
      else if (s_trail && done && tx_full)    reload_pend <= 1'b1;
    end
  end

  assign busy   = m_busy || s_busy;
  assign status = {busy, master_q, cpha_q, cpol_q, sel, nss_i,
                   master_q | sr_empty, master_q | ~rx_full};

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = status;
      A_DATA:  reg_rdata = rxbuf;
      A_DIV:   reg_rdata = 8'(div_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign sck_o   = cpol_q ^ sck_lvl;
  assign sck_oe  = master_q;
  assign mosi_o  = core_out;
  assign mosi_oe = master_q;
  assign miso_o  = core_out;
  assign miso_oe = !master_q && sel;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       master_q,
  input logic       cpol_q,
  input logic       m_busy,
  input logic       s_busy,
  input logic       sck_o,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       nss_i,
  input logic       nss_filt,
  input logic       rx_full,
  input logic       done
);
  logic [2:0] since_rst;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
  end
  assign warm = (since_rst >= 3'd5);

  // R3: idle master clock rests at the polarity level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && !m_busy) |-> (sck_o == cpol_q));

  // R6: filtered select changes only after three equal pin samples
  a_r6_nss_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && (nss_filt != $past(nss_filt))) |->
      ($past(nss_i, 2) == nss_filt && $past(nss_i, 3) == nss_filt
       && $past(nss_i, 4) == nss_filt));

  // R9: reading the data register empties the receive buffer
  a_r9_rx_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && reg_rd && reg_addr == A_DATA && !done) |=> !rx_full);

  // R10: slave-only flags read as ones while master
  a_r10_master_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && reg_addr == A_CFG) |-> (reg_rdata[1:0] == 2'b11));

  // R11: a deselected slave never becomes busy
  a_r11_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && nss_filt) |=> !s_busy);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_q(master_q), .cpol_q(cpol_q),
  .m_busy(m_busy), .s_busy(s_busy), .sck_o(sck_o), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .nss_i(nss_i),
  .nss_filt(nss_filt), .rx_full(rx_full), .done(done)
);

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sck_i, sck_o, sck_oe;
  logic       mosi_i, mosi_o, mosi_oe;
  logic       miso_i, miso_o, miso_oe;
  logic       nss_i;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .nss_i(nss_i)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // All bus tasks start just after a falling clock edge
  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] rd;
    reg_read(2'd0, rd); chk("R1 cfg reset", rd, 8'h07);
    reg_read(2'd2, rd); chk("R1 divider reset", rd, 8'h00);
    chk("R1 sck idle", sck_o, 0);
  endtask

  task automatic t_cfg_rw;
    logic [7:0] rd;
    reg_write(2'd0, 8'hFF);
    reg_read(2'd0, rd); chk("R2 R10 cfg readback", rd, 8'h77);
    reg_write(2'd0, 8'h00);
    reg_read(2'd0, rd); chk("R2 cfg cleared", rd, 8'h07);
  endtask

  task automatic t_nss_glitch;
    logic [7:0] rd;
    nss_i = 1'b0;
    reg_read(2'd0, rd); chk("R7 raw low", rd[2], 0);
    nss_i = 1'b1;
    repeat (6) @(negedge clk);
    reg_read(2'd0, rd); chk("R6 short pulse ignored", rd[3], 0);
    nss_i = 1'b0;
    repeat (3) @(negedge clk);
    nss_i = 1'b1;
    @(negedge clk);
    reg_read(2'd0, rd);
    chk("R6 three-cycle low accepted", rd[3], 1);
    chk("R7 raw high", rd[2], 1);
    repeat (6) @(negedge clk);
    reg_read(2'd0, rd); chk("R6 released", rd[3], 0);
  endtask

  task automatic t_master(input bit pol, input bit pha, input int dv,
                          input logic [7:0] tx, input logic [7:0] sb);
    logic [7:0] rd, got;
    time t1, t2;
    got = '0; t1 = 0; t2 = 0;
    reg_write(2'd2, 8'(dv));
    reg_write(2'd0, {2'b01, pha, pol, 4'b0000});
    chk("R3 master idle level", sck_o, pol);
    miso_i = pha ? 1'b0 : sb[7];
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(sck_o); #1;
          if (i == 0) t1 = $time;
          if (pha) miso_i = sb[7-i];
          else     got = {got[6:0], mosi_o};
          @(sck_o); #1;
          if (i == 0) t2 = $time;
          if (pha)        got = {got[6:0], mosi_o};
          else if (i < 7) miso_i = sb[6-i];
        end
      end
      begin
        reg_write(2'd1, tx);
        repeat (2) @(negedge clk);
        reg_read(2'd0, rd); chk("R4 busy during master transfer", rd[7], 1);
        do reg_read(2'd0, rd); while (rd[7]);
      end
    join
    chk("R5 remote slave saw MOSI byte", got, tx);
    chk("R3 half period", int'(t2 - t1), (dv + 1) * 10);
    chk("R3 idle after transfer", sck_o, pol);
    reg_read(2'd0, rd); chk("R10 master flags", rd[1:0], 2'b11);
    reg_read(2'd1, rd); chk("R4 R5 master received byte", rd, sb);
  endtask

  task automatic bench_clock(input bit pol, input bit pha, input logic [7:0] mb,
                             output logic [7:0] got, input bit probe);
    logic [7:0] rd;
    got = '0;
    for (int i = 0; i < 8; i++) begin
      if (!pha) begin
        mosi_i = mb[7-i];
        repeat (8) @(negedge clk);
        sck_i = ~pol; got = {got[6:0], miso_o};
        repeat (8) @(negedge clk);
        sck_i = pol;
      end else begin
        sck_i = ~pol; mosi_i = mb[7-i];
        repeat (8) @(negedge clk);
        sck_i = pol; got = {got[6:0], miso_o};
        repeat (8) @(negedge clk);
      end
      if (probe && i == 3) begin
        reg_read(2'd0, rd); chk("R12 slave busy mid-byte", rd[7], 1);
      end
    end
  endtask

  task automatic t_slave(input bit pol, input bit pha,
                         input logic [7:0] stx, input logic [7:0] mb);
    logic [7:0] rd, got;
    sck_i = pol;
    reg_write(2'd0, {2'b00, pha, pol, 4'b0000});
    reg_write(2'd1, stx);
    @(negedge clk);
    reg_read(2'd0, rd); chk("R8 empty clears on load", rd[1], 0);
    nss_i = 1'b0;
    repeat (8) @(negedge clk);
    reg_read(2'd0, rd);
    chk("R6 selected", rd[3], 1);
    chk("R7 raw low while selected", rd[2], 0);
    bench_clock(pol, pha, mb, got, 1'b1);
    repeat (6) @(negedge clk);
    reg_read(2'd0, rd);
    chk("R12 slave idle after byte", rd[7], 0);
    chk("R8 empty after byte", rd[1], 1);
    chk("R9 rx not empty", rd[0], 0);
    reg_read(2'd1, rd); chk("R9 R5 slave received byte", rd, mb);
    chk("R5 slave MISO byte", got, stx);
    reg_read(2'd0, rd); chk("R9 rx empty after read", rd[0], 1);
    nss_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_slave_ignored;
    logic [7:0] rd, got;
    sck_i = 1'b0;
    reg_write(2'd0, 8'h00);
    bench_clock(1'b0, 1'b0, 8'hC3, got, 1'b0);
    repeat (6) @(negedge clk);
    reg_read(2'd0, rd);
    chk("R11 no byte received", rd[0], 1);
    chk("R11 empty unchanged", rd[1], 1);
    chk("R11 not busy", rd[7], 0);
  endtask

  task automatic t_slave_edge;
    logic [7:0] rd;
    nss_i = 1'b0;
    repeat (8) @(negedge clk);
    reg_read(2'd0, rd); chk("R8 empty before edge", rd[1], 1);
    sck_i = 1'b1;
    repeat (6) @(negedge clk);
    reg_read(2'd0, rd);
    chk("R8 SCK edge clears empty", rd[1], 0);
    chk("R12 busy from first edge", rd[7], 1);
    sck_i = 1'b0;
    repeat (6) @(negedge clk);
    nss_i = 1'b1;
    repeat (8) @(negedge clk);
    reg_read(2'd0, rd); chk("R12 deselect clears busy", rd[7], 0);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; nss_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_nss_glitch();
    t_master(1'b0, 1'b0, 1, 8'hA5, 8'h3C);
    t_master(1'b0, 1'b1, 0, 8'h81, 8'h7E);
    t_master(1'b1, 1'b0, 2, 8'h5A, 8'hC1);
    t_master(1'b1, 1'b1, 1, 8'h0F, 8'hF0);
    reg_write(2'd0, 8'h00);
    t_slave(1'b0, 1'b0, 8'h96, 8'h2D);
    t_slave(1'b1, 1'b1, 8'h4B, 8'hE7);
    t_slave(1'b0, 1'b1, 8'hD2, 8'h18);
    t_slave_ignored();
    t_slave_edge();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule